// File: doc/BRIEF.md
# Timer Tick Interrupt Entry Sequencer

This block pairs a down-counting interval timer with the stacked interrupt entry of a small core that has a 20-bit address space. Each tick lowers the count by one. On the tick that takes the count from zero to all-ones, the block checks whether the interrupt may be taken. If it may, the block captures the core's program counter, stack pointer and status byte. It then writes a four-byte frame through a byte-wide data memory port, one byte per cycle. After the frame it presents the new stack pointer, the new status byte and the handler address.

The core supplies its live PC, SP, status byte and mask word, together with the vector word it holds for the timer slot. When the entry pulse arrives, the core loads the three result values. An accepted entry costs a fixed number of extra timer ticks. The counter consumes them on its own, one per cycle. The count width defaults to 16 bits.

Top module: `tick_irq_entry`

## Requirements
- R1: While rst_ni is low and just after release, count_o is zero, busy_o, mem_we_o and entry_o are low.
- R2: Each cycle with tick_i high and no latency owed lowers count_o by one, wrapping modulo 2^CNT_W; with tick_i low and nothing owed, count_o holds.
- R3: An entry starts only on the tick where the count goes from zero to all-ones, the sequencer is idle, status bit 7 (IE_BIT) is set, the vector word is non-zero and mask bit 4 (MASK_BIT) is clear.
- R4: A wrap that fails any condition of R3 makes no memory write and no entry pulse, adds no latency, and the count simply continues from all-ones.
- R5: The frame is written in this order: status byte at SP-1, then PC bits 7:0 at SP-4, PC bits 15:8 at SP-3, and {4'h0, PC bits 19:16} at SP-2. SP is the captured stack pointer, arithmetic is modulo 2^16, and every address carries 4'hF in bits 19:16.
- R6: busy_o and mem_we_o are high for exactly the four write cycles, starting in the cycle after the accepting edge.
- R7: entry_o pulses for one cycle right after the last write. While it is high, sp_o equals SP-4, psw_o equals the captured status byte with bit 7 cleared, and pc_o equals the vector word zero-extended to 20 bits.
- R8: An accepted entry owes 9 (LAT) extra decrements, applied one per cycle from the accepting edge. A tick that arrives while latency is owed is deferred, not lost.
- R9: The frame and results use the PC, SP, status and vector values present at the accepting edge. Later changes to those inputs have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timer tick, one decrement per cycle high |
| pc_i | input | 20 | Current return address from the core |
| sp_i | input | 16 | Current stack pointer |
| psw_i | input | 8 | Current status byte |
| mask_i | input | 16 | Interrupt mask word |
| vec_i | input | 16 | Vector word for the timer slot |
| count_o | output | CNT_W | Current timer count |
| busy_o | output | 1 | Frame write sequence in progress |
| mem_we_o | output | 1 | Data memory byte write strobe |
| mem_addr_o | output | 20 | Data memory byte address |
| mem_wdata_o | output | 8 | Data memory write byte |
| entry_o | output | 1 | One-cycle pulse: results valid |
| sp_o | output | 16 | New stack pointer |
| psw_o | output | 8 | New status byte |
| pc_o | output | 20 | Handler address |

## Verification
Some internal faults show at count_o within one or two cycles: a stale owed-latency count, or a wrap test on the wrong count value. Examples are a count that stops short of or runs past the expected value nine cycles after entry, or a spurious entry on a rejected wrap. A sequencer state fault shows as a misordered, missing or extra write at the memory port in the cycle it happens. The scoreboard compares every write and every entry pulse against a frame predicted from the captured inputs. Capture faults show when the bench changes the live inputs during the sequence and a frame byte or result differs.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;
  localparam int PC_W        = 20;
  localparam int SP_W        = 16;
  localparam int BYTE_W      = 8;
  localparam int FRAME_BYTES = 4;
  localparam logic [3:0] STACK_BANK = 4'hF;

  typedef enum logic [2:0] {
    S_IDLE,
    S_STAT,
    S_PC0,
    S_PC1,
    S_PC2,
    S_DONE
  } seq_state_e;
endpackage

// File: rtl/tick_down_counter.sv
module tick_down_counter #(
  parameter int CNT_W  = 16,
  parameter int LAT    = 9,
  parameter int PEND_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             accept_i,
  output logic             wrap_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic              owed, dec;

  assign owed   = (pend_q != '0);
  assign dec    = tick_i | owed;
  assign wrap_o = dec & (cnt_q == '0);
  assign cnt_o  = cnt_q;

  // a tick that lands on an owed cycle replaces the consumed owed tick
  always_comb begin
    pend_d = pend_q;
    if (owed && !tick_i) pend_d = pend_d - 1'b1;
    if (accept_i)        pend_d = pend_d + PEND_W'(LAT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= '0;
    end else begin
      if (dec) cnt_q <= cnt_q - 1'b1;
      pend_q <= pend_d;
    end
  end

  p_dec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_q == ($past(cnt_q) - 1'b1));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !owed) |=> $stable(cnt_q));
  p_owed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> owed);
endmodule

// File: rtl/irq_frame_seq.sv
module irq_frame_seq
  import tick_irq_pkg::*;
#(
  parameter int IE_BIT   = 7,
  parameter int MASK_BIT = 4,
  parameter int MASK_W   = 16,
  parameter int VEC_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wrap_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [SP_W-1:0]   sp_i,
  input  logic [BYTE_W-1:0] psw_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [PC_W-1:0]   mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              entry_o,
  output logic [SP_W-1:0]   sp_o,
  output logic [BYTE_W-1:0] psw_o,
  output logic [PC_W-1:0]   pc_o
);
  localparam int PCX_W = 3 * BYTE_W;

  seq_state_e        state_q, state_d;
  logic [SP_W-1:0]   sp_q, off;
  logic [PC_W-1:0]   pc_q;
  logic [BYTE_W-1:0] psw_q;
  logic [VEC_W-1:0]  vec_q;
  logic [PCX_W-1:0]  pc_ext;
  logic              cond_ok;

  assign cond_ok  = psw_i[IE_BIT] & (vec_i != '0) & ~mask_i[MASK_BIT];
  assign accept_o = wrap_i & (state_q == S_IDLE) & cond_ok;

  always_comb begin
    case (state_q)
      S_IDLE:  state_d = accept_o ? S_STAT : S_IDLE;
      S_STAT:  state_d = S_PC0;
      S_PC0:   state_d = S_PC1;
      S_PC1:   state_d = S_PC2;
      S_PC2:   state_d = S_DONE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      sp_q    <= '0;
      pc_q    <= '0;
      psw_q   <= '0;
      vec_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept_o) begin
        sp_q  <= sp_i;
        pc_q  <= pc_i;
        psw_q <= psw_i;
        vec_q <= vec_i;
      end
    end
  end

  assign pc_ext = {{(PCX_W-PC_W){1'b0}}, pc_q};

  // status byte on top, return address little-endian below it
  always_comb begin
    case (state_q)
      S_STAT:  begin off = SP_W'(1); mem_wdata_o = psw_q;         end
      S_PC0:   begin off = SP_W'(4); mem_wdata_o = pc_ext[7:0];   end
      S_PC1:   begin off = SP_W'(3); mem_wdata_o = pc_ext[15:8];  end
      S_PC2:   begin off = SP_W'(2); mem_wdata_o = pc_ext[23:16]; end
      default: begin off = '0;       mem_wdata_o = '0;            end
    endcase
  end

  assign busy_o     = (state_q == S_STAT) || (state_q == S_PC0) ||
                      (state_q == S_PC1)  || (state_q == S_PC2);
  assign mem_we_o   = busy_o;
  assign mem_addr_o = {STACK_BANK, sp_q - off};
  assign entry_o    = (state_q == S_DONE);
  assign sp_o       = sp_q - SP_W'(FRAME_BYTES);
  assign psw_o      = psw_q & ~(BYTE_W'(1) << IE_BIT);
  assign pc_o       = {{(PC_W-VEC_W){1'b0}}, vec_q};

  p_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> busy_o && mem_addr_o[15:0] == ($past(sp_i) - 16'd1));
  p_entry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> entry_o);
  p_ie_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_o |-> !psw_o[IE_BIT]);
  p_bank_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_addr_o[PC_W-1:SP_W] == STACK_BANK);
  p_one_entry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_o |=> !entry_o);
endmodule

// File: rtl/tick_irq_entry.sv
module tick_irq_entry #(
  parameter int CNT_W    = 16,
  parameter int LAT      = 9,
  parameter int PEND_W   = 8,
  parameter int IE_BIT   = 7,
  parameter int MASK_BIT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [19:0]      pc_i,
  input  logic [15:0]      sp_i,
  input  logic [7:0]       psw_i,
  input  logic [15:0]      mask_i,
  input  logic [15:0]      vec_i,
  output logic [CNT_W-1:0] count_o,
  output logic             busy_o,
  output logic             mem_we_o,
  output logic [19:0]      mem_addr_o,
  output logic [7:0]       mem_wdata_o,
  output logic             entry_o,
  output logic [15:0]      sp_o,
  output logic [7:0]       psw_o,
  output logic [19:0]      pc_o
);
  logic wrap, accept;

  tick_down_counter #(
    .CNT_W (CNT_W),
    .LAT   (LAT),
    .PEND_W(PEND_W)
  ) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .accept_i(accept),
    .wrap_o  (wrap),
    .cnt_o   (count_o)
  );

  irq_frame_seq #(
    .IE_BIT  (IE_BIT),
    .MASK_BIT(MASK_BIT),
    .MASK_W  (16),
    .VEC_W   (16)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wrap_i     (wrap),
    .pc_i       (pc_i),
    .sp_i       (sp_i),
    .psw_i      (psw_i),
    .mask_i     (mask_i),
    .vec_i      (vec_i),
    .accept_o   (accept),
    .busy_o     (busy_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .entry_o    (entry_o),
    .sp_o       (sp_o),
    .psw_o      (psw_o),
    .pc_o       (pc_o)
  );

  p_reject_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && !accept && !busy_o && !entry_o) |=> !busy_o);
endmodule

// File: tb/tb_tick_irq_entry.sv
module tb_tick_irq_entry;
  localparam int CW = 8;
  localparam logic [CW-1:0] ONES = '1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          tick_i = 1'b0;
  logic [19:0]   pc_i = '0;
  logic [15:0]   sp_i = '0;
  logic [7:0]    psw_i = '0;
  logic [15:0]   mask_i = '0;
  logic [15:0]   vec_i = '0;
  logic [CW-1:0] count_o;
  logic          busy_o, mem_we_o, entry_o;
  logic [19:0]   mem_addr_o, pc_o;
  logic [7:0]    mem_wdata_o, psw_o;
  logic [15:0]   sp_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct packed {
    logic        is_entry;
    logic [19:0] addr;
    logic [7:0]  data;
    logic [15:0] sp;
    logic [7:0]  psw;
    logic [19:0] pc;
  } item_t;
  item_t sb[$];

  always #4 clk_i = ~clk_i;

  tick_irq_entry #(.CNT_W(CW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .pc_i(pc_i),
    .sp_i(sp_i), .psw_i(psw_i), .mask_i(mask_i), .vec_i(vec_i),
    .count_o(count_o), .busy_o(busy_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .entry_o(entry_o),
    .sp_o(sp_o), .psw_o(psw_o), .pc_o(pc_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // driver side: predicted frame and result
  task automatic expect_entry(input logic [15:0] sp, input logic [19:0] pc,
                              input logic [7:0] psw, input logic [15:0] vec);
    item_t it;
    it = '0; it.addr = {4'hF, sp - 16'd1}; it.data = psw;                sb.push_back(it);
    it = '0; it.addr = {4'hF, sp - 16'd4}; it.data = pc[7:0];            sb.push_back(it);
    it = '0; it.addr = {4'hF, sp - 16'd3}; it.data = pc[15:8];           sb.push_back(it);
    it = '0; it.addr = {4'hF, sp - 16'd2}; it.data = {4'h0, pc[19:16]};  sb.push_back(it);
    it = '0; it.is_entry = 1'b1; it.sp = sp - 16'd4;
    it.psw = psw & 8'h7F; it.pc = {4'h0, vec};                           sb.push_back(it);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && (mem_we_o || entry_o)) begin
      if (sb.size() == 0) begin
        check("R4 unexpected activity", {30'd0, mem_we_o, entry_o}, 32'd0);
      end else begin
        item_t it;
        it = sb.pop_front();
        if (it.is_entry) begin
          check("R7 entry pulse", {31'd0, entry_o}, 32'd1);
          check("R7 sp_o", {16'd0, sp_o}, {16'd0, it.sp});
          check("R7 psw_o", {24'd0, psw_o}, {24'd0, it.psw});
          check("R7 pc_o", {12'd0, pc_o}, {12'd0, it.pc});
        end else begin
          check("R5 write strobe", {31'd0, mem_we_o}, 32'd1);
          check("R5 addr", {12'd0, mem_addr_o}, {12'd0, it.addr});
          check("R5 data", {24'd0, mem_wdata_o}, {24'd0, it.data});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic tick_once();
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic run_to_zero();
    while (count_o != '0) tick_once();
  endtask

  task automatic reject_case(input string req);
    run_to_zero();
    tick_once();
    check(req, {24'd0, count_o}, {24'd0, ONES});
    check(req, {31'd0, busy_o}, 32'd0);
    @(negedge clk_i);
    check({req, " no latency"}, {24'd0, count_o}, {24'd0, ONES});
    repeat (6) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 count", {24'd0, count_o}, 32'd0);
    check("R1 flags", {29'd0, busy_o, mem_we_o, entry_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release", {24'd0, count_o}, 32'd0);

    // R4: IE clear
    sp_i = 16'hFE00; pc_i = 20'h12345; vec_i = 16'h0100; mask_i = 16'h0000;
    psw_i = 8'h06;
    reject_case("R4 ie clear");

    // R2 decrement and hold
    repeat (3) tick_once();
    check("R2 decrement", {24'd0, count_o}, {24'd0, ONES - 8'd3});
    repeat (2) @(negedge clk_i);
    check("R2 hold", {24'd0, count_o}, {24'd0, ONES - 8'd3});

    // R4: vector zero, then mask bit 4 set
    psw_i = 8'h86; vec_i = 16'h0000;
    reject_case("R4 vec zero");
    vec_i = 16'h0100; mask_i = 16'h0010;
    reject_case("R4 mask set");

    // R3, R5-R9: accepted entry, other mask bits set
    mask_i = 16'hFFEF;
    run_to_zero();
    expect_entry(16'hFE00, 20'h12345, 8'h86, 16'h0100);
    tick_once();
    for (int k = 0; k < 12; k++) begin
      check("R8 latency count", {24'd0, count_o},
            {24'd0, (k <= 9) ? ONES - 8'(k) : ONES - 8'd9});
      check("R6 busy", {31'd0, busy_o}, {31'd0, k < 4});
      if (k == 1) begin
        pc_i = 20'hAAAAA; sp_i = 16'h1234; psw_i = 8'h80; vec_i = 16'h5555;  // R9
      end
      @(negedge clk_i);
    end
    check("R3 frame drained", sb.size(), 32'd0);

    // R8 deferral and R5 stack address wrap
    pc_i = 20'hFABCD; sp_i = 16'h0002; psw_i = 8'hFF; vec_i = 16'hFFFF; mask_i = 16'h0000;
    run_to_zero();
    expect_entry(16'h0002, 20'hFABCD, 8'hFF, 16'hFFFF);
    tick_i = 1'b1;
    @(negedge clk_i);
    for (int k = 0; k < 21; k++) begin
      if (k == 5) tick_i = 1'b0;
      if (k == 14 || k == 20)
        check("R8 deferred tick", {24'd0, count_o}, {24'd0, ONES - 8'd14});
      @(negedge clk_i);
    end
    check("R5 frame drained", sb.size(), 32'd0);

    done = 1;
    summary();
  end
endmodule